// File: doc/BRIEF.md
# UART Transmit Serializer

This block turns characters written by a host into asynchronous serial frames on a single output line. A written character waits in a one-entry holding register. When transmission is allowed, the character moves into a frame register together with its start, parity and stop bits, and the frame is shifted out one bit at a time. The holding register is free again as soon as that move happens, so the host can queue the next character while the current one is still on the line.

Character length (7, 8 or 9 bits), parity (odd, even or none), the number of stop bits (1 or 2), the rate divider `m` and the interrupt point are all chosen at run time. All of them are captured when a character enters the frame register, so the host may change them while a frame is on the line. Bit timing is counted on a source-clock enable (`src_tick`), so a prescaler or an external clock can drive it. An optional clear-to-send gate holds back the start of each new frame. An interrupt pulse reports either the hand-over of a character to the frame register or the end of the frame.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1 and `irq` is 0, and `txd` stays 1 while no frame is active.
- R2: A frame consists of one start bit at 0, followed by the data bits, least significant first. `len_sel` encodes the data length as 0 = 7 bits, 1 = 8 bits, 2 = 9 bits and 3 = 8 bits. Only the low bits of `wr_data` that fit the selected length are sent.
- R3: `par_sel` encodes the parity as 0 = none, 1 = odd, 2 = even and 3 = none. When parity is on, one parity bit follows the last data bit. Odd parity makes the count of ones in the data and parity bits odd, and even parity makes it even.
- R4: After the data and any parity bit come stop bits at 1: one stop bit when `stop2` = 0 and two when `stop2` = 1.
- R5: Every bit lasts 16*(`div_m`+1) cycles in which `src_tick` is 1. With `src_tick` held at 1, the start bit lasts exactly that many clock cycles.
- R6: A character enters the frame register only while `tx_enable` = 1 and the holding register is full (`buf_empty` = 0). Otherwise the line stays idle and the character waits.
- R7: When `cts_gate_en` = 1, a frame may start only while `cts_n` = 0. When `cts_gate_en` = 0, `cts_n` has no effect.
- R8: If `cts_n` rises during a frame, that frame completes normally, and only the start of the next frame is held back.
- R9: `buf_empty` goes to 0 in the cycle after a `wr_stb` pulse. It goes to 1 in the same cycle in which the start bit first appears on `txd`.
- R10: `irq` is a one-cycle pulse, one per frame. If `irq_sel` was 0 at hand-over, the pulse comes in the first start-bit cycle. If it was 1, the pulse comes in the first cycle after the last stop bit.
- R11: If the next character is ready and allowed to start when the last stop bit ends, its start bit follows with no idle cycle in between.
- R12: Length, parity, stop count, divider and interrupt point are captured at hand-over. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 1 | Enable marking one cycle of the bit-rate source clock |
| tx_enable | input | 1 | Permits frames to start |
| wr_stb | input | 1 | Host write strobe into the holding register |
| wr_data | input | 9 | Character to send |
| len_sel | input | 2 | Data length code (0: 7, 1: 8, 2: 9, 3: 8) |
| par_sel | input | 2 | Parity code (0: none, 1: odd, 2: even, 3: none) |
| stop2 | input | 1 | 1 selects two stop bits |
| div_m | input | 8 | Rate divider m; bit time is 16*(m+1) source ticks |
| cts_gate_en | input | 1 | 1 makes frame starts wait for `cts_n` low |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_sel | input | 1 | Interrupt point: 0 at hand-over, 1 at frame end |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | 1 when the holding register can take a character |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach from the ports is a hand-over that happens in the very cycle the previous stop bit ends. The next character has to be written after the first one has left the holding register but before that frame completes. The bench writes the second character as soon as it sees the first start bit, and then measures the gap between the end of one frame and the next start bit, which must be zero. A related case is a clear-to-send change in the middle of a frame. The bench raises `cts_n` only after it has seen a start bit. It then checks that the frame on the line decodes intact, while the queued character stays put until `cts_n` falls again.

// File: rtl/utx_pkg.sv
package utx_pkg;

    // Widest character and widest frame (start + data + parity + 2 stop)
    localparam int DATA_MAX  = 9;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
    localparam int NBITS_W   = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        LEN_7  = 2'd0,
        LEN_8  = 2'd1,
        LEN_9  = 2'd2,
        LEN_8B = 2'd3
    } len_e;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_OFF2 = 2'd3
    } par_e;

    // Prebuilt frame: bit 0 leaves first
    typedef struct packed {
        logic [FRAME_MAX-1:0] word;
        logic [NBITS_W-1:0]   nbits;
    } frame_t;

    function automatic int unsigned data_bits(len_e l);
        case (l)
            LEN_7:   return 7;
            LEN_9:   return 9;
            default: return 8;
        endcase
    endfunction

    function automatic frame_t build_frame(logic [DATA_MAX-1:0] d, len_e l,
                                           par_e p, logic two);
        frame_t f;
        int unsigned n;
        int unsigned pos;
        logic acc;
        n      = data_bits(l);
        f.word = '1;
        f.word[0] = 1'b0;
        acc    = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(n)) begin
                f.word[1+i] = d[i];
                acc         = acc ^ d[i];
            end
        end
        pos = n + 1;
        if (p == PAR_ODD) begin
            f.word[pos] = ~acc;
            pos         = pos + 1;
        end else if (p == PAR_EVEN) begin
            f.word[pos] = acc;
            pos         = pos + 1;
        end
        f.nbits = NBITS_W'(pos + (two ? 2 : 1));
        return f;
    endfunction

endpackage

// File: rtl/utx_bitclk.sv
module utx_bitclk #(
    parameter int M_W = 8,
    parameter int OVS = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           src_tick,
    input  logic [M_W-1:0] m,
    output logic           bit_end
);
    // OVS must be a power of two: limit = OVS*(m+1)-1 = {m, all ones}
    localparam int OB = $clog2(OVS);
    localparam int CW = M_W + OB;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim     = {m, {OB{1'b1}}};
    assign bit_end = run && src_tick && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (src_tick) begin
            cnt <= (cnt == lim) ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/utx_shift.sv
module utx_shift #(
    parameter int W  = 13,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_word,
    input  logic [NW-1:0] load_nbits,
    input  logic          bit_end,
    output logic          txd,
    output logic          active,
    output logic          last_end
);
    logic [W-1:0]  sh;
    logic [NW-1:0] left;

    assign txd      = active ? sh[0] : 1'b1;
    assign last_end = bit_end && (left == NW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            left   <= '0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= load_word;
            left   <= load_nbits;
            active <= 1'b1;
        end else if (bit_end) begin
            sh   <= {1'b1, sh[W-1:1]};
            left <= left - NW'(1);
            if (left == NW'(1)) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import utx_pkg::*;
#(
    parameter int M_W = 8,
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                src_tick,
    input  logic                tx_enable,
    input  logic                wr_stb,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic [1:0]          len_sel,
    input  logic [1:0]          par_sel,
    input  logic                stop2,
    input  logic [M_W-1:0]      div_m,
    input  logic                cts_gate_en,
    input  logic                cts_n,
    input  logic                irq_sel,
    output logic                txd,
    output logic                buf_empty,
    output logic                irq
);
    logic [DATA_MAX-1:0] hold_q;
    logic [M_W-1:0]      m_q;
    logic                sel_q;
    logic                active;
    logic                last_end;
    logic                bit_end;
    logic                cts_ok;
    logic                slot_free;
    logic                load;
    frame_t              nxt;

    // Start condition: enabled, character waiting, clear to send, line free
    assign cts_ok    = !cts_gate_en || !cts_n;
    assign slot_free = !active || last_end;
    assign load      = tx_enable && !buf_empty && cts_ok && slot_free;
    assign nxt       = build_frame(hold_q, len_e'(len_sel), par_e'(par_sel), stop2);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            buf_empty <= 1'b1;
        end else if (wr_stb) begin
            hold_q    <= wr_data;
            buf_empty <= 1'b0;
        end else if (load) begin
            buf_empty <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q   <= '0;
            sel_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= (load && !irq_sel) || (last_end && sel_q);
            if (load) begin
                m_q   <= div_m;
                sel_q <= irq_sel;
            end
        end
    end

    utx_bitclk #(.M_W(M_W), .OVS(OVS)) i_bitclk (
        .clk      (clk),
        .rst      (rst),
        .run      (active),
        .src_tick (src_tick),
        .m        (m_q),
        .bit_end  (bit_end)
    );

    utx_shift #(.W(FRAME_MAX), .NW(NBITS_W)) i_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_word  (nxt.word),
        .load_nbits (nxt.nbits),
        .bit_end    (bit_end),
        .txd        (txd),
        .active     (active),
        .last_end   (last_end)
    );
endmodule

// File: rtl/utx_chk.sv
module utx_chk (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic tx_enable,
    input logic cts_gate_en,
    input logic cts_n,
    input logic irq_sel,
    input logic txd,
    input logic buf_empty,
    input logic irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (txd && buf_empty && !irq));

    // R9
    buf_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(buf_empty) |-> $past(wr_stb));

    // R6
    start_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) |-> $past(tx_enable));

    // R7
    cts_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(buf_empty) && $past(cts_gate_en)) |-> !$past(cts_n));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R10
    irq_handover_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(buf_empty) && !$past(irq_sel)) |-> irq);
endmodule

bind uart_tx_serializer utx_chk i_utx_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .tx_enable   (tx_enable),
    .cts_gate_en (cts_gate_en),
    .cts_n       (cts_n),
    .irq_sel     (irq_sel),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .irq         (irq)
);

// File: tb/test_uart_tx_serializer.sv
`timescale 1ns/1ps
module test_uart_tx_serializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_tick = 1'b1;
    logic       tx_enable = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] len_sel = 2'd1;
    logic [1:0] par_sel = 2'd0;
    logic       stop2 = 1'b0;
    logic [7:0] div_m = 8'd0;
    logic       cts_gate_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       irq_sel = 1'b0;
    logic       txd, buf_empty, irq;

    int nvec = 0;
    int nfail = 0;
    int tick_div = 1;
    int tphase = 0;
    longint cyc = 0;

    always #2.5 clk = ~clk;

    uart_tx_serializer i_uart_tx_serializer (
        .clk(clk), .rst(rst), .src_tick(src_tick), .tx_enable(tx_enable),
        .wr_stb(wr_stb), .wr_data(wr_data), .len_sel(len_sel), .par_sel(par_sel),
        .stop2(stop2), .div_m(div_m), .cts_gate_en(cts_gate_en), .cts_n(cts_n),
        .irq_sel(irq_sel), .txd(txd), .buf_empty(buf_empty), .irq(irq)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected frame from the requirements; bit 0 leaves first
    function automatic logic [15:0] ref_frame(logic [8:0] d, int ls, int ps, bit two,
                                              output int nb, output int nd, output bit hp);
        logic [15:0] w;
        int k;
        int ones;
        w    = '1;
        w[0] = 1'b0;
        nd   = (ls == 0) ? 7 : (ls == 2) ? 9 : 8;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            w[i+1] = d[i];
            ones   = ones + int'(d[i]);
        end
        k  = nd + 1;
        hp = (ps == 1) || (ps == 2);
        if (ps == 1) begin w[k] = (ones % 2 == 0); k++; end
        if (ps == 2) begin w[k] = (ones % 2 == 1); k++; end
        nb = k + (two ? 2 : 1);
        return w;
    endfunction

    // Line monitor
    logic [8:0]  exp_q[$];
    bit          inf = 0;
    int          mc, mP, mN, mD, msel, mdiv, frames_seen = 0, irq_seen = 0;
    bit          mhp;
    logic [15:0] mexp, obits;
    logic [8:0]  mdata;
    longint      last_end = 0, gap = -1;

    task automatic close_frame();
        bit dok, pok, sok;
        dok = 1; pok = 1; sok = 1;
        for (int i = 1; i <= mD; i++) if (obits[i] !== mexp[i]) dok = 0;
        if (mhp && obits[mD+1] !== mexp[mD+1]) pok = 0;
        for (int i = mN - ((mN - mD - (mhp ? 1 : 0) - 1)); i < mN; i++)
            if (obits[i] !== 1'b1) sok = 0;
        chk(dok, "R2 data bits", longint'(obits), longint'(mexp));
        chk(pok, "R3 parity bit", longint'(obits), longint'(mexp));
        chk(sok, "R4 stop bits", longint'(obits), longint'(mexp));
        if (msel == 1 && mdiv == 1) chk(irq === 1'b1, "R10 irq at frame end", irq, 1);
        frames_seen++;
        last_end = cyc;
    endtask

    always @(negedge clk) begin
        cyc++;
        tphase   = (tphase + 1) % tick_div;
        src_tick = (tphase == 0);
        if (!rst) begin
            if (irq === 1'b1) irq_seen++;
            if (inf) begin
                mc++;
                if ((mc % mP) == mP / 2 && (mc / mP) < mN) obits[mc/mP] = txd;
                if (mdiv == 1 && mexp[1] == 1'b1 && mc == mP - 1)
                    chk(txd === 1'b0, "R5 start bit still low", txd, 0);
                if (mdiv == 1 && mexp[1] == 1'b1 && mc == mP)
                    chk(txd === 1'b1, "R5 start bit ends", txd, 1);
                if (mc == mN * mP) begin
                    inf = 0;
                    close_frame();
                end
            end
            if (!inf && txd === 1'b0) begin
                inf  = 1;
                mc   = 0;
                obits = '1;
                mdiv = tick_div;
                mP   = tick_div * 16 * (int'(div_m) + 1);
                msel = irq_sel;
                gap  = cyc - last_end;
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected frame", 1, 0);
                    mdata = '0;
                end else begin
                    mdata = exp_q.pop_front();
                end
                mexp = ref_frame(mdata, len_sel, par_sel, stop2, mN, mD, mhp);
                if (msel == 0) chk(irq === 1'b1, "R10 irq at hand-over", irq, 1);
            end
        end
    end

    task automatic wr(logic [8:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        exp_q.push_back(d);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic set_cfg(int ls, int ps, bit two, int m, bit sel);
        len_sel = 2'(ls);
        par_sel = 2'(ps);
        stop2   = two;
        div_m   = 8'(m);
        irq_sel = sel;
    endtask

    task automatic wait_quiet();
        while (exp_q.size() != 0 || inf || !buf_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        finish_run();
    end

    initial begin
        int nf;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1 && buf_empty === 1'b1 && irq === 1'b0, "R1 reset state",
            {txd, buf_empty, irq}, 3'b110);

        // R6 / R9: character waits while transmit is disabled
        set_cfg(1, 0, 0, 0, 0);
        wr(9'h0A5);
        chk(buf_empty === 1'b0, "R9 write fills buffer", buf_empty, 0);
        repeat (100) @(negedge clk);
        chk(txd === 1'b1 && buf_empty === 1'b0, "R6 held while disabled", {txd, buf_empty}, 2'b10);
        tx_enable = 1'b1;
        wait (inf);
        chk(buf_empty === 1'b1, "R9 buffer empties at start bit", buf_empty, 1);
        wait_quiet();

        // R7: gate on, cts high holds the start
        cts_gate_en = 1'b1;
        cts_n = 1'b1;
        set_cfg(0, 1, 1, 1, 1);
        wr(9'h03C);
        repeat (120) @(negedge clk);
        chk(txd === 1'b1 && buf_empty === 1'b0, "R7 held by cts", {txd, buf_empty}, 2'b10);
        cts_n = 1'b0;
        wait_quiet();

        // R7: gate off, cts ignored
        cts_gate_en = 1'b0;
        cts_n = 1'b1;
        set_cfg(2, 2, 0, 0, 0);
        wr(9'h1C3);
        repeat (40) @(negedge clk);
        chk(inf == 1 || frames_seen == 3, "R7 cts ignored when gate off", inf, 1);
        wait_quiet();

        // R8: cts rises mid-frame
        cts_gate_en = 1'b1;
        cts_n = 1'b0;
        set_cfg(1, 1, 0, 0, 1);
        wr(9'h05A);
        wait (inf);
        nf = frames_seen;
        cts_n = 1'b1;
        wr(9'h0F0);
        wait (frames_seen == nf + 1);
        repeat (60) @(negedge clk);
        chk(frames_seen == nf + 1, "R8 frame completes", frames_seen, nf + 1);
        chk(txd === 1'b1 && buf_empty === 1'b0, "R8 next start held", {txd, buf_empty}, 2'b10);
        cts_n = 1'b0;
        wait_quiet();
        cts_gate_en = 1'b0;

        // R11: back-to-back frames without idle
        set_cfg(1, 0, 0, 0, 1);
        wr(9'h0FF);
        wait (inf);
        wr(9'h011);
        wait_quiet();
        chk(gap == 0, "R11 no idle between frames", gap, 0);

        // R12: configuration changed during a frame
        nf = nfail;
        set_cfg(2, 2, 1, 1, 0);
        wr(9'h1B7);
        wait (inf);
        repeat (20) @(negedge clk);
        set_cfg(0, 1, 0, 3, 1);
        wait_quiet();
        chk(nfail == nf, "R12 frame keeps captured config", nfail - nf, 0);

        // R5: largest divider
        set_cfg(1, 0, 0, 255, 1);
        wr(9'h0A5);
        wait_quiet();

        // R5: source ticks every other cycle
        tick_div = 2;
        set_cfg(1, 1, 1, 1, 0);
        wr(9'h0C7);
        wait_quiet();
        tick_div = 1;

        // Random frames
        for (int i = 0; i < 40; i++) begin
            set_cfg($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                    $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            wr(9'($urandom));
            wait_quiet();
        end

        // R10: one pulse per frame
        chk(irq_seen == frames_seen, "R10 one irq per frame", irq_seen, frames_seen);
        chk(exp_q.size() == 0, "R6 every character sent", exp_q.size(), 0);
        finish_run();
    end
endmodule